// File: doc/BRIEF.md
# Two-Mode Mesh Route Selector and Output Arbiter

This block sits inside one router of a two-dimensional mesh. Each of the five inputs (four neighbour directions plus local injection) can present the first flit of a packet together with its destination coordinates. For each such head the block chooses one output port. In the calm mode it always resolves the horizontal offset before the vertical one. In the busy mode it looks at one congestion flag per directional output and, when both a horizontal and a vertical step would bring the packet closer, it takes the step whose output is not flagged.

Heads that want the same free output are settled by a fixed ranking of the inputs. A winner keeps its output across all of its flits until the flit marked as the tail goes through. Losers stay where they are and compete again on the next cycle. The router's own position in the mesh is a build parameter. Flit storage and the measurement of congestion belong to neighbouring logic.

Top module: `noc_pxy_switch`

## Requirements
- R1: With `adapt_mode` low, a head routes on X first: east (port code 2) when destination X exceeds the router's X, west (3) when it is below. With X equal it routes north (0) when destination Y is larger, south (1) when it is smaller, and local (4) when both match. `out_hot` has no effect in this mode.
- R2: With `adapt_mode` high and both coordinates differing, the head takes the vertical step only when the horizontal output is flagged in `out_hot` and the vertical one is not. Otherwise it takes the horizontal step. `out_hot` bit 0 is north, 1 south, 2 east, 3 west.
- R3: With `adapt_mode` high and only one coordinate differing, the head takes that single minimal direction even if its output is flagged.
- R4: Among fresh heads wanting the same free output, the winner is the highest-ranked input: north (input 0), then south (1), then east (2), then west (3).
- R5: The local input (4) is granted an output only when no directional input presents a fresh head for that output in the same cycle.
- R6: A head that loses stays granted-low while its request stays up. It is granted in the first cycle its output is free again.
- R7: Once a head is granted without a tail mark, its input keeps `in_gnt` high and the same `in_port` value until a requested flit with the tail mark passes. No other input is granted that output meanwhile.
- R8: A single-flit packet (head and tail marked together) frees its output at the next clock, so another head can win in the following cycle.
- R9: Heads wanting different free outputs are all granted in the same cycle.
- R10: With no request present, no grant is raised. After reset every output is free.
- R11: Changing `adapt_mode` or `out_hot` while a packet holds an output does not change that packet's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| adapt_mode | input | 1 | 1 selects the congestion-aware mode |
| out_hot | input | 4 | Congestion flag per directional output (N,S,E,W at bits 0..3) |
| in_req | input | 5 | Flit present, per input (N,S,E,W,local) |
| in_head | input | 5 | Flit is a packet head, per input |
| in_tail | input | 5 | Flit ends the packet, per input |
| in_dst_x | input | 5*COORD_W | Destination X per input, input i at slice i |
| in_dst_y | input | 5*COORD_W | Destination Y per input, input i at slice i |
| in_gnt | output | 5 | Grant per input, combinational in the flit's cycle |
| in_port | output | 15 | Chosen output code per input, 3 bits each |

## Verification
A stale hold flag shows up at the ports in the same cycle. The input's `in_gnt` stays high after its tail, or a fresh head for that output is refused with no visible owner. A hold register that captured the wrong port makes `in_port` jump between body flits, and this is visible on the flit after the head. Route errors are purely combinational, so a wrong direction or a wrong congestion preference appears on `in_port` in the very cycle the head is presented.

// File: rtl/noc_pxy_pkg.sv
package noc_pxy_pkg;
  localparam int NPORT  = 5;
  localparam int PORT_W = 3;

  typedef enum logic [2:0] {
    P_N = 3'd0, P_S = 3'd1, P_E = 3'd2, P_W = 3'd3, P_L = 3'd4
  } port_e;

  // Minimal-direction choice for one head; coordinates zero-extended to 8 bits.
  function automatic logic [2:0] route_pick(
    input logic       adapt,
    input logic [3:0] hot,
    input logic [7:0] cx, input logic [7:0] cy,
    input logic [7:0] dx, input logic [7:0] dy);
    logic [2:0] xp, yp;
    logic       hx, hy;
    xp = (dx > cx) ? P_E : P_W;
    yp = (dy > cy) ? P_N : P_S;
    hx = (xp == P_E) ? hot[2] : hot[3];
    hy = (yp == P_N) ? hot[0] : hot[1];
    if (dx == cx && dy == cy)   route_pick = P_L;
    else if (dy == cy)          route_pick = xp;
    else if (dx == cx)          route_pick = yp;
    else if (!adapt)            route_pick = xp;
    else if (hx && !hy)         route_pick = yp;
    else                        route_pick = xp;
  endfunction
endpackage

// File: rtl/noc_route_calc.sv
module noc_route_calc
  import noc_pxy_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter int MY_X    = 2,
  parameter int MY_Y    = 2
) (
  input  logic               adapt,
  input  logic [3:0]         hot,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  output logic [PORT_W-1:0]  want
);
  localparam logic [7:0] CX = 8'(MY_X);
  localparam logic [7:0] CY = 8'(MY_Y);

  always_comb want = route_pick(adapt, hot, CX, CY, 8'(dst_x), 8'(dst_y));
endmodule

// File: rtl/noc_out_arb.sv
module noc_out_arb
  import noc_pxy_pkg::*;
(
  input  logic [NPORT-1:0] cand,
  input  logic             taken,
  output logic [NPORT-1:0] win
);
  // Lowest index is highest rank: N, S, E, W, then local.
  always_comb win = taken ? '0 : (cand & (~cand + NPORT'(1)));
endmodule

// File: rtl/noc_hold_reg.sv
module noc_hold_reg
  import noc_pxy_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              drop,
  input  logic [PORT_W-1:0] port_in,
  output logic              busy,
  output logic [PORT_W-1:0] port_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      port_q <= '0;
    end else if (take) begin
      busy   <= 1'b1;
      port_q <= port_in;
    end else if (drop) begin
      busy   <= 1'b0;
    end
  end
endmodule

// File: rtl/noc_pxy_switch.sv
module noc_pxy_switch
  import noc_pxy_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter int MY_X    = 2,
  parameter int MY_Y    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adapt_mode,
  input  logic [3:0]               out_hot,
  input  logic [NPORT-1:0]         in_req,
  input  logic [NPORT-1:0]         in_head,
  input  logic [NPORT-1:0]         in_tail,
  input  logic [NPORT*COORD_W-1:0] in_dst_x,
  input  logic [NPORT*COORD_W-1:0] in_dst_y,
  output logic [NPORT-1:0]         in_gnt,
  output logic [NPORT*PORT_W-1:0]  in_port
);
  logic [PORT_W-1:0] want   [NPORT];
  logic [PORT_W-1:0] held   [NPORT];
  logic [NPORT-1:0]  busy;
  logic [NPORT-1:0]  fresh;
  logic [NPORT-1:0]  new_gnt;
  logic [NPORT-1:0]  cand   [NPORT];
  logic [NPORT-1:0]  win    [NPORT];
  logic [NPORT-1:0]  taken;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    noc_route_calc #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_rc (
      .adapt (adapt_mode),
      .hot   (out_hot),
      .dst_x (in_dst_x[i*COORD_W +: COORD_W]),
      .dst_y (in_dst_y[i*COORD_W +: COORD_W]),
      .want  (want[i])
    );

    assign fresh[i] = in_req[i] & in_head[i] & ~busy[i];

    noc_hold_reg u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (new_gnt[i] & ~in_tail[i]),
      .drop    (busy[i] & in_req[i] & in_tail[i]),
      .port_in (want[i]),
      .busy    (busy[i]),
      .port_q  (held[i])
    );

    assign in_gnt[i]                   = busy[i] | new_gnt[i];
    assign in_port[i*PORT_W +: PORT_W] = busy[i] ? held[i] : want[i];
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    always_comb begin
      taken[o] = 1'b0;
      for (int i = 0; i < NPORT; i++) begin
        cand[o][i] = fresh[i] && (want[i] == PORT_W'(o));
        if (busy[i] && held[i] == PORT_W'(o)) taken[o] = 1'b1;
      end
    end

    noc_out_arb u_arb (
      .cand  (cand[o]),
      .taken (taken[o]),
      .win   (win[o])
    );
  end

  always_comb begin
    new_gnt = '0;
    for (int o = 0; o < NPORT; o++) new_gnt = new_gnt | win[o];
  end
endmodule

// File: rtl/noc_pxy_switch_chk.sv
module noc_pxy_switch_chk
  import noc_pxy_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter int MY_X    = 2,
  parameter int MY_Y    = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     adapt_mode,
  input logic [NPORT-1:0]         in_req,
  input logic [NPORT-1:0]         in_head,
  input logic [NPORT-1:0]         in_tail,
  input logic [NPORT*COORD_W-1:0] in_dst_x,
  input logic [NPORT*COORD_W-1:0] in_dst_y,
  input logic [NPORT-1:0]         in_gnt,
  input logic [NPORT*PORT_W-1:0]  in_port
);
  logic [PORT_W-1:0] ps [NPORT];
  for (genvar i = 0; i < NPORT; i++) begin : g_ps
    assign ps[i] = in_port[i*PORT_W +: PORT_W];
  end

  // Each output has at most one granted user (R7, R9).
  for (genvar o = 0; o < NPORT; o++) begin : g_one
    logic [NPORT-1:0] users;
    always_comb
      for (int i = 0; i < NPORT; i++)
        users[i] = in_gnt[i] && ps[i] == PORT_W'(o);
    assert_one_user_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(users));
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    assert_hold_until_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_gnt[i] && in_req[i] && !in_tail[i]) |=>
        (in_gnt[i] && ps[i] == $past(ps[i])));

    assert_x_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!adapt_mode && in_req[i] && in_head[i] &&
       in_dst_x[i*COORD_W +: COORD_W] != COORD_W'(MY_X)) |->
        (ps[i] == P_E || ps[i] == P_W));

    assert_single_dim_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (adapt_mode && in_req[i] && in_head[i] &&
       in_dst_x[i*COORD_W +: COORD_W] == COORD_W'(MY_X) &&
       in_dst_y[i*COORD_W +: COORD_W] >  COORD_W'(MY_Y)) |->
        (ps[i] == P_N));
  end

  // North only loses a fresh head to an input that owns the same output (R4).
  logic [NPORT-1:0] n_owner;
  always_comb begin
    n_owner = '0;
    for (int j = 1; j < NPORT; j++) n_owner[j] = in_gnt[j] && ps[j] == ps[0];
  end
  assert_north_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req[0] && in_head[0] && !in_gnt[0]) |-> (n_owner != '0));

  // A fresh local head granted means no directional fresh head wants that output (R5).
  logic [3:0] dir_rival;
  always_comb
    for (int j = 0; j < 4; j++)
      dir_rival[j] = in_req[j] && in_head[j] && ps[j] == ps[4];
  assert_local_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req[4] && in_head[4] && in_gnt[4]) |-> (dir_rival == 4'b0));
endmodule

bind noc_pxy_switch noc_pxy_switch_chk #(
  .COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .adapt_mode (adapt_mode),
  .in_req     (in_req),
  .in_head    (in_head),
  .in_tail    (in_tail),
  .in_dst_x   (in_dst_x),
  .in_dst_y   (in_dst_y),
  .in_gnt     (in_gnt),
  .in_port    (in_port)
);

// File: tb/noc_pxy_switch_test.sv
module noc_pxy_switch_test;
  localparam int CW = 3;
  localparam int NP = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          adapt_mode;
  logic [3:0]    out_hot;
  logic [NP-1:0] in_req, in_head, in_tail;
  logic [NP*CW-1:0] in_dst_x, in_dst_y;
  logic [NP-1:0] in_gnt;
  logic [NP*3-1:0] in_port;

  int nvec = 0;
  int nbad = 0;

  always #4 clk = ~clk;  // 125 MHz

  noc_pxy_switch #(.COORD_W(CW), .MY_X(2), .MY_Y(2)) uut (
    .clk(clk), .rst_n(rst_n), .adapt_mode(adapt_mode), .out_hot(out_hot),
    .in_req(in_req), .in_head(in_head), .in_tail(in_tail),
    .in_dst_x(in_dst_x), .in_dst_y(in_dst_y),
    .in_gnt(in_gnt), .in_port(in_port)
  );

  // Independent route model: router sits at (2,2).
  function automatic int exp_port(bit mode, logic [3:0] hot, int x, int y);
    int ox = x - 2;
    int oy = y - 2;
    int hd = (ox > 0) ? 2 : 3;
    int vd = (oy > 0) ? 0 : 1;
    if (ox == 0 && oy == 0) return 4;
    if (ox == 0) return vd;
    if (oy == 0) return hd;
    if (mode && hot[hd] && !hot[vd]) return vd;
    return hd;
  endfunction

  task automatic check(string tag, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int port_of(int i);
    return int'(in_port[i*3 +: 3]);
  endfunction

  task automatic put(int i, bit r, bit h, bit t, int x, int y);
    in_req[i]  = r;
    in_head[i] = h;
    in_tail[i] = t;
    in_dst_x[i*CW +: CW] = CW'(x);
    in_dst_y[i*CW +: CW] = CW'(y);
  endtask

  task automatic clear_all();
    in_req = '0; in_head = '0; in_tail = '0;
    in_dst_x = '0; in_dst_y = '0;
    adapt_mode = 1'b0; out_hot = 4'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic one_head(string tag, int i, bit mode, logic [3:0] hot, int x, int y);
    adapt_mode = mode; out_hot = hot;
    put(i, 1, 1, 1, x, y);
    #1;
    check({tag, " gnt"}, int'(in_gnt[i]), 1);
    check({tag, " port"}, port_of(i), exp_port(mode, hot, x, y));
    step();
    clear_all();
  endtask

  task automatic t_reset();
    clear_all();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 gnt in reset", int'(in_gnt), 0);
    rst_n = 1'b1;
    step();
    #1;
    check("R10 idle after reset", int'(in_gnt), 0);
    step();
  endtask

  task automatic t_xy();
    one_head("R1 east",  0, 0, 4'b0000, 3, 1);
    one_head("R1 west",  1, 0, 4'b0000, 0, 4);
    one_head("R1 north", 1, 0, 4'b0000, 2, 4);
    one_head("R1 south", 0, 0, 4'b0000, 2, 0);
    one_head("R1 local", 2, 0, 4'b0000, 2, 2);
    one_head("R1 hot ignored", 3, 0, 4'b1111, 3, 4);
  endtask

  task automatic t_adapt();
    one_head("R2 both clear", 0, 1, 4'b0000, 3, 4);
    one_head("R2 east hot",   0, 1, 4'b0100, 3, 4);
    one_head("R2 both hot",   0, 1, 4'b0101, 3, 4);
    one_head("R2 west hot",   2, 1, 4'b1000, 0, 0);
    one_head("R3 north only", 1, 1, 4'b0001, 2, 4);
    one_head("R3 east only",  3, 1, 4'b0100, 4, 2);
  endtask

  task automatic t_prio();
    for (int i = 0; i < NP; i++) put(i, 1, 1, 1, 3, 2);
    for (int w = 0; w < NP; w++) begin
      #1;
      check($sformatf("R4 R6 R8 winner round %0d", w), int'(in_gnt), 1 << w);
      check("R4 winner port east", port_of(w), 2);
      step();
      put(w, 0, 0, 0, 0, 0);
    end
    #1;
    check("R5 all served", int'(in_gnt), 0);
    clear_all();
  endtask

  task automatic t_hold();
    put(3, 1, 1, 0, 3, 0);
    #1;
    check("R7 head granted", int'(in_gnt[3]), 1);
    check("R7 head port east", port_of(3), 2);
    step();
    put(3, 1, 0, 0, 3, 0);
    put(2, 1, 1, 1, 3, 2);
    adapt_mode = 1'b1; out_hot = 4'b0100;
    #1;
    check("R7 body keeps grant", int'(in_gnt[3]), 1);
    check("R11 held port unchanged", port_of(3), 2);
    check("R7 rival blocked", int'(in_gnt[2]), 0);
    step();
    put(3, 1, 0, 1, 3, 0);
    #1;
    check("R7 tail flit granted", int'(in_gnt[3]), 1);
    check("R6 rival still waiting", int'(in_gnt[2]), 0);
    step();
    put(3, 0, 0, 0, 0, 0);
    #1;
    check("R6 rival granted after tail", int'(in_gnt), 5'b00100);
    check("R6 rival port", port_of(2), 2);
    step();
    clear_all();
    #1;
    check("R8 all free", int'(in_gnt), 0);
  endtask

  task automatic t_parallel();
    put(0, 1, 1, 1, 3, 2);
    put(1, 1, 1, 1, 0, 2);
    put(2, 1, 1, 1, 2, 4);
    put(3, 1, 1, 1, 2, 2);
    #1;
    check("R9 all four granted", int'(in_gnt), 5'b01111);
    check("R9 N->E", port_of(0), 2);
    check("R9 S->W", port_of(1), 3);
    check("R9 E->N", port_of(2), 0);
    check("R9 W->L", port_of(3), 4);
    step();
    clear_all();
  endtask

  task automatic t_local();
    put(4, 1, 1, 1, 2, 4);
    put(3, 1, 1, 1, 2, 4);
    #1;
    check("R5 west beats local", int'(in_gnt), 5'b01000);
    step();
    put(3, 0, 0, 0, 0, 0);
    #1;
    check("R5 local after west", int'(in_gnt), 5'b10000);
    check("R5 local port north", port_of(4), 0);
    step();
    clear_all();
  endtask

  initial begin
    #(8 * 200000);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    t_reset();
    t_xy();
    t_adapt();
    t_prio();
    t_hold();
    t_parallel();
    t_local();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule